// File: doc/BRIEF.md
# Triple-Voted Two-Wire Configuration Slave

This block sits on a shared two-wire serial bus (one clock line and one data line, driven by a single master) and gives the master access to a small bank of byte-wide configuration registers. Each slave on the bus answers to its own 7-bit address, which is strapped in through a port. A write transaction carries the slave address with the write direction, then a register index, then one data byte. A read transaction sends the slave address and the register index in the same way. It then issues a repeated start and the slave address with the read direction, and the slave returns one byte.

Every configuration bit is held in three flip-flops. The value seen by the chip and by the bus is the 2-of-3 majority of those copies. On every system clock all three copies are reloaded with the voted value, so an upset in any single copy is masked at once and then scrubbed away. A register write loads the new byte into all three copies on the same edge.

The bus lines are oversampled by the system clock. SDA is driven in open-drain fashion: the block only pulls it low, through `sda_oe`.

Top module: `tv_cfg_slave`

## Requirements
- R1: After reset every byte of `cfg_q` is 0x00 and `sda_oe` is low.
- R2: The slave pulls SDA low during the ninth clock of the address byte only when the first seven received bits, MSB first, equal `dev_addr`. The eighth bit is the direction: 0 means write and 1 means read.
- R3: On an address mismatch the slave acknowledges nothing and changes no register until the next start condition.
- R4: A write frame (address+write, index, data, stop) acknowledges all three bytes. Data byte N appears on `cfg_q[8*N+7:8*N]` for index N below NREG.
- R5: A read frame (address+write, index, repeated start, address+read) returns the voted register, MSB first. The slave has SDA released during the master's acknowledge clock that follows.
- R6: For an index of NREG or above, the index is still acknowledged, the write changes no register, and a read returns 0x00.
- R7: An upset of one stored copy of any bit leaves `cfg_q` unchanged.
- R8: Each clock, all copies are rewritten with the majority value. After a one-copy upset is released, a later upset of a different copy at the same bit is still masked.
- R9: A write that commits while one copy of the target register is corrupted leaves all three copies holding the new byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_addr | input | 7 | Strapped slave address |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_out | output | 1 | Value driven on SDA when enabled (always 0) |
| sda_oe | output | 1 | High pulls SDA low |
| cfg_q | output | NREG*8 | Voted register bank, register N on bits 8N+7..8N |

## Verification
A bus write can commit on the same clock in which the scrub logic is repairing a corrupted copy of the target register. The bench provokes this by holding one copy of a register at a wrong value for the whole write transaction and then releasing it. It judges the outcome by upsetting a second copy at the same bits afterwards. `cfg_q` must still show the written byte, which can only happen if the write and the scrub together left the other copies correct.

// File: rtl/tv_cfg_slave.sv
module tv_cfg_slave #(
  parameter int NREG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        dev_addr,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_out,
  output logic              sda_oe,
  output logic [NREG*8-1:0] cfg_q
);
  localparam int W     = NREG * 8;
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DEV_ACK, S_REG, S_REG_ACK,
    S_DATA, S_DATA_ACK, S_TX, S_TX_ACK
  } st_t;

  st_t        state;
  logic [1:0] scl_m, sda_m;
  logic       scl_d, sda_d;
  logic [3:0] cnt;
  logic [7:0] sh, txsh, ptr;
  logic       rw, drv;
  logic [W-1:0] rep0, rep1, rep2, voted, nxt;

  wire scl_s = scl_m[1];
  wire sda_s = sda_m[1];
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire start_c = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c  = scl_s & scl_d & ~sda_d & sda_s;
  wire ptr_ok = (ptr < 8'(NREG));
  wire [IDX_W-1:0] idx = ptr[IDX_W-1:0];
  wire [7:0] lane = 8'(voted >> (idx * 8));
  wire [7:0] rd_byte = ptr_ok ? lane : 8'h00;
  wire wr_pulse = (state == S_DATA) & scl_fall & (cnt == 4'd8) & ~start_c & ~stop_c;

  assign voted   = (rep0 & rep1) | (rep0 & rep2) | (rep1 & rep2);
  assign cfg_q   = voted;
  assign sda_out = 1'b0;
  assign sda_oe  = drv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 2'b11; sda_m <= 2'b11; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_m <= {scl_m[0], scl_in};
      sda_m <= {sda_m[0], sda_in};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  always_comb begin
    nxt = voted;
    if (wr_pulse && ptr_ok)
      for (int i = 0; i < NREG; i++)
        if (idx == IDX_W'(i)) nxt[i*8 +: 8] = sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep0 <= '0; rep1 <= '0; rep2 <= '0;
    end else begin
      rep0 <= nxt; rep1 <= nxt; rep2 <= nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; sh <= '0; txsh <= '0;
      ptr <= '0; rw <= 1'b0; drv <= 1'b0;
    end else if (start_c) begin
      state <= S_DEV; cnt <= '0; drv <= 1'b0;
    end else if (stop_c) begin
      state <= S_IDLE; cnt <= '0; drv <= 1'b0;
    end else begin
      if (scl_rise) begin
        case (state)
          S_DEV, S_REG, S_DATA: begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end
          S_TX: cnt <= cnt + 4'd1;
          default: ;
        endcase
      end
      if (scl_fall) begin
        case (state)
          S_DEV: if (cnt == 4'd8) begin
            cnt <= '0;
            if (sh[7:1] == dev_addr) begin
              rw <= sh[0]; drv <= 1'b1; state <= S_DEV_ACK;
            end else begin
              state <= S_IDLE;
            end
          end
          S_REG: if (cnt == 4'd8) begin
            cnt <= '0; ptr <= sh; drv <= 1'b1; state <= S_REG_ACK;
          end
          S_DATA: if (cnt == 4'd8) begin
            cnt <= '0; drv <= 1'b1; state <= S_DATA_ACK;
          end
          S_DEV_ACK: begin
            cnt <= '0;
            if (rw) begin
              txsh <= rd_byte; drv <= ~rd_byte[7]; state <= S_TX;
            end else begin
              drv <= 1'b0; state <= S_REG;
            end
          end
          S_REG_ACK:  begin drv <= 1'b0; state <= S_DATA; end
          S_DATA_ACK: begin drv <= 1'b0; state <= S_IDLE; end
          S_TX: if (cnt == 4'd8) begin
            drv <= 1'b0; state <= S_TX_ACK;
          end else begin
            txsh <= {txsh[6:0], 1'b0}; drv <= ~txsh[6];
          end
          S_TX_ACK: state <= S_IDLE;
          default: ;
        endcase
      end
    end
  end

  AST_RESET_CLEAN: assert property (@(posedge clk) $rose(rst_n) |-> (cfg_q == '0) && !sda_oe); // R1
  AST_NO_ACK_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DEV) && scl_fall && (cnt == 4'd8) && (sh[7:1] != dev_addr) && !start_c && !stop_c
    |=> !sda_oe && (state == S_IDLE)); // R3
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse && ptr_ok |=> lane == $past(sh)); // R4
  AST_OOR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse && !ptr_ok |=> $stable(cfg_q)); // R6
  AST_VOTE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pulse |=> $stable(cfg_q)); // R7
  AST_TX_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_TX_ACK |-> !sda_oe); // R5
endmodule

// File: tb/tv_cfg_slave_tb.sv
`timescale 1ns/1ps
module tv_cfg_slave_tb;
  localparam int NREG = 8;
  localparam int Q = 10;
  localparam logic [6:0] ADDR = 7'h2A;
  localparam int NV = 6;
  localparam logic [23:0] VEC [NV] = '{
    {8'd0, 8'hA5, 8'hA5}, {8'd3, 8'h3C, 8'h3C}, {8'd7, 8'hFF, 8'hFF},
    {8'd5, 8'h00, 8'h00}, {8'd9, 8'h77, 8'h00}, {8'd2, 8'h81, 8'h81}
  };

  logic clk = 0, rst_n = 0, m_scl = 1, m_sda = 1;
  logic sda_out, sda_oe;
  logic [NREG*8-1:0] cfg_q, exp_q, upset_val;
  int checks = 0, fails = 0;
  bit done = 0;
  wire sda_bus = sda_oe ? sda_out : m_sda;

  always #2 clk = ~clk;

  tv_cfg_slave #(.NREG(NREG)) u_dut (
    .clk(clk), .rst_n(rst_n), .dev_addr(ADDR), .scl_in(m_scl), .sda_in(sda_bus),
    .sda_out(sda_out), .sda_oe(sda_oe), .cfg_q(cfg_q));

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic i2c_start; m_sda = 1; m_scl = 1; wq(Q); m_sda = 0; wq(Q); m_scl = 0; wq(Q); endtask
  task automatic i2c_rstart; m_sda = 1; wq(Q); m_scl = 1; wq(Q); m_sda = 0; wq(Q); m_scl = 0; wq(Q); endtask
  task automatic i2c_stop; m_sda = 0; wq(Q); m_scl = 1; wq(Q); m_sda = 1; wq(Q); endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(Q); m_scl = 1; wq(Q); m_scl = 0; wq(2);
    end
    m_sda = 1; wq(Q); m_scl = 1; wq(Q/2); ack = ~sda_bus; wq(Q/2); m_scl = 0; wq(2);
  endtask

  task automatic recv_byte(output logic [7:0] b, output logic rel);
    m_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); m_scl = 1; wq(Q/2); b[i] = sda_bus; wq(Q/2); m_scl = 0; wq(2);
    end
    m_sda = 1; wq(Q); m_scl = 1; wq(Q/2); rel = sda_bus; wq(Q/2); m_scl = 0; wq(2);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] ix, input logic [7:0] d,
                          output logic [2:0] acks);
    i2c_start;
    send_byte({a, 1'b0}, acks[2]);
    send_byte(ix, acks[1]);
    send_byte(d, acks[0]);
    i2c_stop;
  endtask

  task automatic do_read(input logic [7:0] ix, output logic [7:0] d, output logic [2:0] acks,
                         output logic rel);
    i2c_start;
    send_byte({ADDR, 1'b0}, acks[2]);
    send_byte(ix, acks[1]);
    i2c_rstart;
    send_byte({ADDR, 1'b1}, acks[0]);
    recv_byte(d, rel);
    i2c_stop;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [2:0] acks;
    logic [7:0] rd;
    logic rel;
    exp_q = '0;
    wq(5);
    chk("R1 cfg_q after reset", 64'(cfg_q), 64'(0));
    chk("R1 sda_oe after reset", 64'(sda_oe), 64'(0));
    rst_n = 1; wq(5);
    chk("R1 cfg_q out of reset", 64'(cfg_q), 64'(0));

    for (int v = 0; v < NV; v++) begin
      logic [7:0] ix, wd, ex;
      {ix, wd, ex} = VEC[v];
      do_write(ADDR, ix, wd, acks);
      if (ix < NREG) exp_q[ix*8 +: 8] = wd;
      chk("R2 R4 R6 write acks", 64'(acks), 64'(3'b111));
      chk("R4 R6 cfg_q after write", 64'(cfg_q), 64'(exp_q));
      do_read(ix, rd, acks, rel);
      chk("R2 R5 read acks", 64'(acks), 64'(3'b111));
      chk("R5 R6 read data", 64'(rd), 64'(ex));
      chk("R5 sda released at master ack", 64'(rel), 64'(1));
    end

    do_write(7'h2B, 8'd1, 8'h11, acks);
    chk("R2 R3 no ack on wrong address", 64'(acks), 64'(0));
    chk("R3 no register change", 64'(cfg_q), 64'(exp_q));
    do_write(7'h6A, 8'd6, 8'h99, acks);
    chk("R2 R3 no ack on upper-bit mismatch", 64'(acks), 64'(0));
    chk("R3 no register change 2", 64'(cfg_q), 64'(exp_q));
    do_write(ADDR, 8'd6, 8'h6E, acks);
    exp_q[6*8 +: 8] = 8'h6E;
    chk("R3 next start decodes again", 64'(cfg_q), 64'(exp_q));

    upset_val = exp_q ^ (64'(1) << 13);
    force u_dut.rep1 = upset_val; wq(3);
    chk("R7 one-copy upset masked", 64'(cfg_q), 64'(exp_q));
    release u_dut.rep1; wq(3);
    force u_dut.rep2 = upset_val; wq(3);
    chk("R8 scrubbed copy outvotes second upset", 64'(cfg_q), 64'(exp_q));
    release u_dut.rep2; wq(3);
    force u_dut.rep0 = upset_val; wq(3);
    chk("R7 R8 third copy upset masked", 64'(cfg_q), 64'(exp_q));
    release u_dut.rep0; wq(3);

    upset_val = exp_q;
    upset_val[4*8 +: 8] = 8'hC3;
    force u_dut.rep1 = upset_val;
    do_write(ADDR, 8'd4, 8'h5A, acks);
    exp_q[4*8 +: 8] = 8'h5A;
    chk("R9 write during corrupt copy", 64'(cfg_q), 64'(exp_q));
    release u_dut.rep1; wq(3);
    upset_val = exp_q;
    upset_val[4*8 +: 8] = 8'hA5;
    force u_dut.rep2 = upset_val; wq(3);
    chk("R9 all copies hold new byte", 64'(cfg_q), 64'(exp_q));
    release u_dut.rep2; wq(3);
    do_read(8'd4, rd, acks, rel);
    chk("R5 R9 read back written byte", 64'(rd), 64'(8'h5A));

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule